// File: doc/BRIEF.md
# Saturating 40-bit accumulator adder

This block is the add unit of a DSP datapath. It adds a 40-bit accumulator either to a second accumulator or to a 32-bit register pair. The result is written back in one of two forms. It can be a 40-bit accumulator value, or a 32-bit value split into an even and an odd 16-bit register. Clamping to the signed 32-bit range has two sources. For the accumulator form, a mode bit turns it on. For the register-pair forms, an opcode bit turns it on, and that form also updates two condition flags. A clear operation zeroes the accumulator.

The caller presents the operands, an operation code, the two saturation controls and the current flag values, and pulses `start`. On the next clock edge the result, the destination kind and the new flag values are registered, and `out_valid` is high for that one cycle. Only the outputs that belong to the chosen destination are updated. The other outputs hold their previous value.

Top module: `sacc_top`

## Requirements
- R1: With `op_sel`=2'b00 and `sat_mode`=0, `res_acc` is the sum of `acc_a` and `opnd_b`, both sign-extended from bit 39, truncated to 40 bits. `sat_op` has no effect on this operation.
- R2: With `op_sel`=2'b00 and `sat_mode`=1, a sum above 2^31-1 gives `res_acc`=40'h007FFFFFFF, a sum below -2^31 gives 40'hFF80000000, and any other sum is truncated to 40 bits.
- R3: With `op_sel`=2'b01, the low 32 bits of `opnd_b` are a signed register pair and bits 39:32 are ignored. The pair is sign-extended and added to `acc_a`. Sum bits 31:16 go to `pair_even` and sum bits 15:0 go to `pair_odd`. `sat_mode` has no effect.
- R4: In a register-pair operation with `sat_op`=1, the sum is clamped to the signed 32-bit range (7FFFFFFF or 80000000). The new `flag_f1` is the incoming `f0_in`. The new `flag_f0` is 1 when clamping occurred and 0 when it did not.
- R5: For every operation other than a register-pair operation with `sat_op`=1, `flag_f0` and `flag_f1` take the values of `f0_in` and `f1_in` as sampled at `start`.
- R6: With `op_sel`=2'b11, `res_acc` becomes zero in all 40 bits.
- R7: Operations 00 and 11 set `dest_pair`=0 and update only `res_acc`. Operations 01 and 10 set `dest_pair`=1 and update only `pair_even` and `pair_odd`. The outputs of the other destination keep their previous value.
- R8: `out_valid` is high in exactly the cycle after each cycle in which `start` is high, and low otherwise. Without `start`, all result and flag outputs hold.
- R9: With `op_sel`=2'b10, the sum of the two sign-extended accumulators is written to the register pair. The truncation, clamp and flag rules of R3 and R4 apply.
- R10: After reset, `out_valid`, `dest_pair`, all result outputs and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins one operation |
| op_sel | input | 2 | 00 acc+acc to acc, 01 acc+pair to pair, 10 acc+acc to pair, 11 clear |
| sat_mode | input | 1 | Clamp enable for the accumulator-destination add |
| sat_op | input | 1 | Selects the saturating, flag-updating register-pair form |
| acc_a | input | 40 | First accumulator operand |
| opnd_b | input | 40 | Second accumulator, or register pair in bits 31:0 |
| f0_in | input | 1 | Current F0 flag |
| f1_in | input | 1 | Current F1 flag |
| out_valid | output | 1 | Result valid for one cycle |
| dest_pair | output | 1 | 1 when the result targets a register pair |
| res_acc | output | 40 | Accumulator result |
| pair_even | output | 16 | Pair result bits 31:16 |
| pair_odd | output | 16 | Pair result bits 15:0 |
| flag_f0 | output | 1 | Updated F0 flag |
| flag_f1 | output | 1 | Updated F1 flag |

## Verification
The assertions check on every cycle the properties that hold regardless of the arithmetic:
- the one-cycle valid timing;
- that a saturated accumulator result stays within the 32-bit signed range;
- clear to zero;
- the F1-from-F0 copy and the passing through of flags in non-saturating forms;
- that the other destination's outputs stay stable.

Exact sums, where truncation occurs versus where clamping occurs at the ±2^31 boundaries, the wrap at the 40-bit extremes, and whether the clamp flag is correct can only be shown by the bench. The bench sweeps corner operand sets across every operation, saturation setting and flag combination, and compares each result against arithmetic computed in the bench.

// File: rtl/sacc_pkg.sv
package sacc_pkg;
  typedef enum logic [1:0] {
    OP_ACC_ACC  = 2'b00,
    OP_ACC_PAIR = 2'b01,
    OP_ACC_2PR  = 2'b10,
    OP_CLEAR    = 2'b11
  } sacc_op_e;
endpackage

// File: rtl/sacc_operand_sel.sv
module sacc_operand_sel
  import sacc_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int PAIR_W = 32
) (
  input  logic [1:0]       op_sel,
  input  logic [ACC_W-1:0] opnd_b,
  output logic [ACC_W-1:0] ext_b
);
  localparam int PAD_W = ACC_W - PAIR_W;

  // register pair: low PAIR_W bits, sign-extended; upper bits discarded
  always_comb begin
    if (op_sel == OP_ACC_PAIR)
      ext_b = {{PAD_W{opnd_b[PAIR_W-1]}}, opnd_b[PAIR_W-1:0]};
    else
      ext_b = opnd_b;
  end
endmodule

// File: rtl/sacc_add_clamp.sv
module sacc_add_clamp #(
  parameter int ACC_W  = 40,
  parameter int PAIR_W = 32
) (
  input  logic [ACC_W-1:0] a,
  input  logic [ACC_W-1:0] b,
  input  logic             clamp_en,
  output logic [ACC_W-1:0] sum_out,
  output logic             clamped
);
  localparam int SUM_W = ACC_W + 1;
  localparam int TOP_W = SUM_W - PAIR_W + 1;
  localparam logic signed [SUM_W-1:0] LIM_HI = {{TOP_W{1'b0}}, {(PAIR_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] LIM_LO = {{TOP_W{1'b1}}, {(PAIR_W-1){1'b0}}};

  logic signed [SUM_W-1:0] full_sum;
  logic                    over_hi;
  logic                    under_lo;

  always_comb begin
    full_sum = $signed({a[ACC_W-1], a}) + $signed({b[ACC_W-1], b});
    over_hi  = full_sum > LIM_HI;
    under_lo = full_sum < LIM_LO;
    clamped  = clamp_en & (over_hi | under_lo);
    if (clamp_en && over_hi)
      sum_out = LIM_HI[ACC_W-1:0];
    else if (clamp_en && under_lo)
      sum_out = LIM_LO[ACC_W-1:0];
    else
      sum_out = full_sum[ACC_W-1:0];
  end
endmodule

// File: rtl/sacc_flag_next.sv
module sacc_flag_next (
  input  logic sat_pair,
  input  logic clamped,
  input  logic f0_in,
  input  logic f1_in,
  output logic f0_nx,
  output logic f1_nx
);
  always_comb begin
    if (sat_pair) begin
      f1_nx = f0_in;
      f0_nx = clamped;
    end else begin
      f1_nx = f1_in;
      f0_nx = f0_in;
    end
  end
endmodule

// File: rtl/sacc_top.sv
module sacc_top
  import sacc_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int PAIR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op_sel,
  input  logic              sat_mode,
  input  logic              sat_op,
  input  logic [ACC_W-1:0]  acc_a,
  input  logic [ACC_W-1:0]  opnd_b,
  input  logic              f0_in,
  input  logic              f1_in,
  output logic              out_valid,
  output logic              dest_pair,
  output logic [ACC_W-1:0]  res_acc,
  output logic [PAIR_W/2-1:0] pair_even,
  output logic [PAIR_W/2-1:0] pair_odd,
  output logic              flag_f0,
  output logic              flag_f1
);
  localparam int HALF = PAIR_W / 2;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic             is_pair, sat_pair, clamp_en, clamped;
  logic             load_acc, load_pair;
  logic [ACC_W-1:0] ext_b, sum_val, acc_nx;
  logic             f0_nx, f1_nx;

  always_comb begin
    is_pair   = (op_sel == OP_ACC_PAIR) || (op_sel == OP_ACC_2PR);
    sat_pair  = is_pair & sat_op;
    clamp_en  = is_pair ? sat_op : ((op_sel == OP_ACC_ACC) & sat_mode);
    load_acc  = start & ~is_pair;
    load_pair = start & is_pair;
    acc_nx    = (op_sel == OP_CLEAR) ? '0 : sum_val;
  end

  sacc_operand_sel #(.ACC_W(ACC_W), .PAIR_W(PAIR_W)) u_opsel (
    .op_sel (op_sel),
    .opnd_b (opnd_b),
    .ext_b  (ext_b)
  );

  sacc_add_clamp #(.ACC_W(ACC_W), .PAIR_W(PAIR_W)) u_add (
    .a        (acc_a),
    .b        (ext_b),
    .clamp_en (clamp_en),
    .sum_out  (sum_val),
    .clamped  (clamped)
  );

  sacc_flag_next u_flags (
    .sat_pair (sat_pair),
    .clamped  (clamped),
    .f0_in    (f0_in),
    .f1_in    (f1_in),
    .f0_nx    (f0_nx),
    .f1_nx    (f1_nx)
  );

  // result registers with explicit enables
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid <= 1'b0;
      dest_pair <= 1'b0;
      flag_f0   <= 1'b0;
      flag_f1   <= 1'b0;
      res_acc   <= '0;
      pair_even <= '0;
      pair_odd  <= '0;
    end else begin
      out_valid <= start;
      if (start) begin
        dest_pair <= is_pair;
        flag_f0   <= f0_nx;
        flag_f1   <= f1_nx;
      end
      if (load_acc)
        res_acc <= acc_nx;
      if (load_pair) begin
        pair_even <= sum_val[PAIR_W-1:HALF];
        pair_odd  <= sum_val[HALF-1:0];
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_q)
    start |=> out_valid);  // R8
  AST_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_q)
    !start |=> !out_valid);  // R8
  AST_ACC_SAT_RANGE: assert property (@(posedge clk) disable iff (!rst_q)
    (start && op_sel == OP_ACC_ACC && sat_mode) |=>
      (res_acc[ACC_W-1:PAIR_W-1] == '0 || res_acc[ACC_W-1:PAIR_W-1] == '1));  // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_q)
    (start && op_sel == OP_CLEAR) |=> (res_acc == '0));  // R6
  AST_FLAG_PASS: assert property (@(posedge clk) disable iff (!rst_q)
    (start && !sat_pair) |=> (flag_f0 == $past(f0_in) && flag_f1 == $past(f1_in)));  // R5
  AST_F1_COPY: assert property (@(posedge clk) disable iff (!rst_q)
    (start && sat_pair) |=> (flag_f1 == $past(f0_in)));  // R4
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    (start && !is_pair) |=> ($stable(pair_even) && $stable(pair_odd) && !dest_pair));  // R7
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    (start && is_pair) |=> ($stable(res_acc) && dest_pair));  // R7
endmodule

// File: tb/sacc_top_bench.sv
module sacc_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  op_sel;
  logic        sat_mode, sat_op, f0_in, f1_in;
  logic [39:0] acc_a, opnd_b;
  logic        out_valid, dest_pair, flag_f0, flag_f1;
  logic [39:0] res_acc;
  logic [15:0] pair_even, pair_odd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [39:0] accv [12];
  logic [31:0] pairv [8];
  logic [39:0] exp_acc;
  logic [31:0] exp_pair;

  always #5 clk = ~clk;

  sacc_top u_sacc_top (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .sat_mode(sat_mode), .sat_op(sat_op), .acc_a(acc_a), .opnd_b(opnd_b),
    .f0_in(f0_in), .f1_in(f1_in), .out_valid(out_valid), .dest_pair(dest_pair),
    .res_acc(res_acc), .pair_even(pair_even), .pair_odd(pair_odd),
    .flag_f0(flag_f0), .flag_f1(flag_f1)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic longint sx40(input logic [39:0] v);
    return longint'({{24{v[39]}}, v});
  endfunction

  // one operation: drive at negedge, check at the following negedge
  task automatic run_op(input logic [1:0] op, input bit sm, input bit so,
                        input logic [39:0] a, input logic [39:0] b,
                        input bit f0, input bit f1);
    longint s, lo, hi;
    bit pair_op, clip, ef0, ef1;
    logic [39:0] old_acc;
    logic [31:0] old_pair;
    lo = -(64'sd1 <<< 31);
    hi = (64'sd1 <<< 31) - 1;
    op_sel = op; sat_mode = sm; sat_op = so; acc_a = a; opnd_b = b;
    f0_in = f0; f1_in = f1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pair_op = (op == 2'b01) || (op == 2'b10);
    if (op == 2'b01) s = sx40(a) + longint'({{32{b[31]}}, b[31:0]});
    else             s = sx40(a) + sx40(b);
    clip = 1'b0;
    if ((pair_op && so) || (op == 2'b00 && sm)) begin
      if (s > hi) begin s = hi; clip = 1'b1; end
      else if (s < lo) begin s = lo; clip = 1'b1; end
    end
    old_acc = exp_acc; old_pair = exp_pair;
    if (op == 2'b11) exp_acc = '0;
    else if (!pair_op) exp_acc = s[39:0];
    else exp_pair = s[31:0];
    ef0 = (pair_op && so) ? clip : f0;
    ef1 = (pair_op && so) ? f0 : f1;
    check(out_valid === 1'b1, "R8 valid", {63'd0, out_valid}, 64'd1);
    check(dest_pair === pair_op, "R7 dest", {63'd0, dest_pair}, {63'd0, pair_op});
    if (pair_op) begin
      check({pair_even, pair_odd} === exp_pair,
            (op == 2'b01) ? (so ? "R4 pair sat" : "R3 pair sum") : "R9 acc to pair",
            {32'd0, pair_even, pair_odd}, {32'd0, exp_pair});
      check(res_acc === old_acc, "R7 acc hold", {24'd0, res_acc}, {24'd0, old_acc});
    end else begin
      check(res_acc === exp_acc,
            (op == 2'b11) ? "R6 clear" : (sm ? "R2 acc sat" : "R1 acc sum"),
            {24'd0, res_acc}, {24'd0, exp_acc});
      check({pair_even, pair_odd} === old_pair, "R7 pair hold",
            {32'd0, pair_even, pair_odd}, {32'd0, old_pair});
    end
    check(flag_f0 === ef0, (pair_op && so) ? "R4 f0" : "R5 f0",
          {63'd0, flag_f0}, {63'd0, ef0});
    check(flag_f1 === ef1, (pair_op && so) ? "R4 f1" : "R5 f1",
          {63'd0, flag_f1}, {63'd0, ef1});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    accv[0] = 40'h0000000000; accv[1]  = 40'h0000000001; accv[2]  = 40'h007FFFFFFF;
    accv[3] = 40'h0080000000; accv[4]  = 40'hFF80000000; accv[5]  = 40'hFF7FFFFFFF;
    accv[6] = 40'h7FFFFFFFFF; accv[7]  = 40'h8000000000; accv[8]  = 40'hFFFFFFFFFF;
    accv[9] = 40'h0012345678; accv[10] = 40'hFFEDCBA988; accv[11] = 40'h3FFFFFFFFF;
    pairv[0] = 32'h00000000; pairv[1] = 32'h00000001; pairv[2] = 32'h7FFFFFFF;
    pairv[3] = 32'h80000000; pairv[4] = 32'hFFFFFFFF; pairv[5] = 32'h40000000;
    pairv[6] = 32'hC0000000; pairv[7] = 32'h12345678;
    exp_acc = '0; exp_pair = '0;
    rst_n = 1'b0; start = 1'b0; op_sel = 2'b00; sat_mode = 1'b0; sat_op = 1'b0;
    acc_a = '0; opnd_b = '0; f0_in = 1'b1; f1_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(out_valid === 1'b0 && dest_pair === 1'b0, "R10 ctl", {62'd0, out_valid, dest_pair}, 64'd0);
    check(res_acc === '0 && pair_even === '0 && pair_odd === '0, "R10 data",
          {24'd0, res_acc}, 64'd0);
    check(flag_f0 === 1'b0 && flag_f1 === 1'b0, "R10 flags", {62'd0, flag_f0, flag_f1}, 64'd0);

    // R1 R2: acc+acc to acc, sat_op toggled to show it is ignored
    for (int sm = 0; sm < 2; sm++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          run_op(2'b00, sm[0], j[0], accv[i], accv[j], i[0], i[1]);
    // R3 R4: acc+pair to pair, upper operand bits junk, sat_mode toggled
    for (int so = 0; so < 2; so++)
      for (int fl = 0; fl < 4; fl++)
        for (int i = 0; i < 12; i++)
          for (int j = 0; j < 8; j++)
            run_op(2'b01, j[0], so[0], accv[i], {8'hA5 ^ 8'(i * 29 + j), pairv[j]},
                   fl[0], fl[1]);
    // R9 R4: acc+acc to pair
    for (int so = 0; so < 2; so++)
      for (int fl = 0; fl < 4; fl++)
        for (int i = 0; i < 12; i++)
          for (int j = 0; j < 12; j++)
            run_op(2'b10, i[0], so[0], accv[i], accv[j], fl[0], fl[1]);
    // R6 clear after a nonzero accumulator result, with varied inputs
    for (int i = 0; i < 12; i++) begin
      run_op(2'b00, 1'b0, 1'b0, accv[i], accv[1], 1'b1, 1'b0);
      run_op(2'b11, i[0], i[1], accv[i], accv[(i + 5) % 12], i[2], i[0]);
    end
    // R8: idle cycles, no valid and all outputs hold
    for (int k = 0; k < 3; k++) begin
      acc_a = accv[k + 2]; opnd_b = accv[k + 6]; op_sel = 2'(k); f0_in = ~flag_f0;
      @(negedge clk);
      check(out_valid === 1'b0, "R8 idle valid", {63'd0, out_valid}, 64'd0);
      check(res_acc === exp_acc && {pair_even, pair_odd} === exp_pair, "R8 idle hold",
            {24'd0, res_acc}, {24'd0, exp_acc});
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule